// File: doc/BRIEF.md
# Programmable Chip-Select Window Decoder

This block sits between a bus master and a set of memory and peripheral ports. Each port owns a window of the 32-bit address space, given by a base address and a power-of-two size. When the master starts an access, the block finds the port whose window holds the address. It then drives that port's own strobe and terminates every beat with an acknowledge, timed by the wait-state count programmed for that port. Some ports are marked as DRAM-type. For those, the block drives a row strobe in place of the plain select.

Every port also carries its own data path width, which is reported while the access runs so that an external bus sizer can act on it. It further carries a single-word or burst mode: burst beats after the first take one clock each. Software programs the ports through a simple register write port. Port 0 comes out of reset covering the whole address space at 8-bit width, so boot code can be fetched before any setup is done. An address that falls in no enabled window ends in a bus error after a fixed timeout.

Top module: `csdec_top`

## Requirements
- R1: After reset, port 0 is enabled with a window covering all 4 GB, 8-bit width, single mode and the largest wait count; every other port is disabled. Any address therefore selects port 0.
- R2: An enabled port matches when the address bits at and above bit `log2(size)` equal the same bits of its base. Base bits below the size are ignored. Register select 0 writes the base, select 1 writes log2(size) from data bits 5:0, and select 2 writes the control word.
- R3: A written log2(size) below 12 is stored as 12 (4 KB), and one above 28 is stored as 28 (256 MB).
- R4: When enabled windows overlap, the lowest-numbered matching port wins.
- R5: During an access to a matched port, exactly one strobe is active: `ras_o[i]` if the port's DRAM bit (control bit 4) is set, otherwise `cs_o[i]`. No strobe is active when idle.
- R6: The first beat of an access lasts wait+2 clocks. `ack_o` is high in its last clock, where wait is control bits 11:8. Counting the clock after the start edge as clock 1, the first ack falls in clock wait+2.
- R7: On a port in burst mode (control bit 3 set), each beat after the first lasts exactly 1 clock.
- R8: On a port in single mode, every beat of a multi-beat access lasts wait+2 clocks.
- R9: While busy, `width_o` gives the selected port's width: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, taken from control bits 2:1. A written code of 3 is stored as 2.
- R10: An access matching no enabled window drives no strobe and raises `err_o` for one clock, TIMEOUT clocks after the start edge.
- R11: A port whose enable bit (control bit 0) is clear never matches.
- R12: `bus_start` is ignored while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | PIDX_W | Port addressed by the write |
| cfg_sel | input | 2 | Register select: 0 base, 1 size, 2 control |
| cfg_wdata | input | 32 | Write data |
| bus_start | input | 1 | Start of an access (sampled when idle) |
| bus_addr | input | 32 | Access address, sampled with the start |
| bus_beats | input | BEAT_W | Beat count of the access (0 means 1) |
| cs_o | output | NPORTS | Per-port select strobes |
| ras_o | output | NPORTS | Per-port row strobes for DRAM-type ports |
| ack_o | output | 1 | Beat termination |
| err_o | output | 1 | Bus error for an unmapped address |
| busy_o | output | 1 | Access in progress |
| width_o | output | 2 | Data path width code of the selected port |

## Verification
Some properties are checked on every clock. At most one strobe is ever active. A termination always comes with a strobe, and an error never does. A burst beat is followed at once by the next ack. A single-mode ack is never directly followed by another. The width code stays put during an access, and the stored size never leaves its legal range. The bench scenarios cover what needs concrete numbers. They show which port a given address reaches under overlap, disabling and size clamping, and the exact clock of each ack or error for given wait counts. They also show that a start pulse raised in the middle of an access leaves no trace.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  localparam int ADDR_W   = 32;
  localparam int WAIT_W   = 4;
  localparam int SIZE_W   = 6;
  localparam int MIN_LOG2 = 12;
  localparam int MAX_LOG2 = 28;
  localparam int FULL_LOG2 = ADDR_W;

  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_16 = 2'd1,
    WID_32 = 2'd2
  } width_e;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_SIZE = 2'd1,
    SEL_CTRL = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic              en;
    logic [1:0]        width;
    logic              burst;
    logic              dram;
    logic [WAIT_W-1:0] waits;
    logic [ADDR_W-1:0] base;
    logic [SIZE_W-1:0] lg2;
  } port_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_MISS = 2'd2
  } cyc_state_e;
endpackage

// File: rtl/csdec_port_regs.sv
module csdec_port_regs
  import csdec_pkg::*;
#(
  parameter bit IS_BOOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output port_cfg_t         cfg_o
);
  localparam port_cfg_t RST_VAL = IS_BOOT ?
    '{en: 1'b1, width: WID_8,  burst: 1'b0, dram: 1'b0, waits: '1,
      base: '0, lg2: SIZE_W'(FULL_LOG2)} :
    '{en: 1'b0, width: WID_32, burst: 1'b0, dram: 1'b0, waits: '1,
      base: '0, lg2: SIZE_W'(MAX_LOG2)};

  port_cfg_t         cfg_q, cfg_d;
  logic [SIZE_W-1:0] lg2_req, lg2_fit;
  logic [1:0]        width_req;

  always_comb begin
    lg2_req = wr_data[SIZE_W-1:0];
    if (lg2_req < SIZE_W'(MIN_LOG2))      lg2_fit = SIZE_W'(MIN_LOG2);
    else if (lg2_req > SIZE_W'(MAX_LOG2)) lg2_fit = SIZE_W'(MAX_LOG2);
    else                                  lg2_fit = lg2_req;
    width_req = (wr_data[2:1] == 2'b11) ? WID_32 : wr_data[2:1];
  end

  always_comb begin
    cfg_d = cfg_q;
    case (wr_sel)
      SEL_BASE: cfg_d.base = wr_data;
      SEL_SIZE: cfg_d.lg2  = lg2_fit;
      SEL_CTRL: begin
        cfg_d.en    = wr_data[0];
        cfg_d.width = width_req;
        cfg_d.burst = wr_data[3];
        cfg_d.dram  = wr_data[4];
        cfg_d.waits = wr_data[8 +: WAIT_W];
      end
      default: cfg_d = cfg_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= RST_VAL;
    else if (wr_en) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  // R3
  size_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_q.lg2 >= SIZE_W'(MIN_LOG2)) && (cfg_q.lg2 <= SIZE_W'(MAX_LOG2)))
    || (IS_BOOT && (cfg_q.lg2 == SIZE_W'(FULL_LOG2))));

  // R9
  width_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.width != 2'b11);
endmodule

// File: rtl/csdec_window_match.sv
module csdec_window_match
  import csdec_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int PIDX_W = $clog2(NPORTS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPORTS-1:0] en_i,
  input  logic [ADDR_W-1:0] base_i [NPORTS],
  input  logic [SIZE_W-1:0] lg2_i  [NPORTS],
  output logic              hit_o,
  output logic [PIDX_W-1:0] idx_o
);
  logic [NPORTS-1:0] hit_vec;

  for (genvar g = 0; g < NPORTS; g++) begin : g_win
    assign hit_vec[g] = en_i[g] && (((addr_i ^ base_i[g]) >> lg2_i[g]) == '0);
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NPORTS - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_o = 1'b1;
        idx_o = PIDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/csdec_cycle_ctrl.sv
module csdec_cycle_ctrl
  import csdec_pkg::*;
#(
  parameter int NPORTS  = 4,
  parameter int BEAT_W  = 4,
  parameter int TIMEOUT = 16,
  parameter int PIDX_W  = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BEAT_W-1:0] beats_i,
  input  logic              hit_i,
  input  logic [PIDX_W-1:0] idx_i,
  input  logic [1:0]        width_i,
  input  logic              burst_i,
  input  logic              dram_i,
  input  logic [WAIT_W-1:0] waits_i,
  output logic [NPORTS-1:0] cs_o,
  output logic [NPORTS-1:0] ras_o,
  output logic              ack_o,
  output logic              err_o,
  output logic              busy_o,
  output logic [1:0]        width_o
);
  localparam int TO_W  = $clog2(TIMEOUT + 1);
  localparam int CNT_W = (TO_W > WAIT_W + 1) ? TO_W : WAIT_W + 1;

  cyc_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BEAT_W-1:0] left_q, left_d;
  logic [PIDX_W-1:0] idx_q;
  logic [1:0]        width_q;
  logic              burst_q, dram_q;
  logic [WAIT_W-1:0] waits_q;
  logic              accept, cnt_done, act;
  logic [CNT_W-1:0]  first_len, next_len;

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign cnt_done  = (cnt_q == '0);
  assign act       = (state_q == ST_ACT);
  assign first_len = CNT_W'(waits_i) + CNT_W'(1);
  assign next_len  = burst_q ? '0 : (CNT_W'(waits_q) + CNT_W'(1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    left_d  = left_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          left_d = (beats_i == '0) ? '0 : beats_i - BEAT_W'(1);
          if (hit_i) begin
            state_d = ST_ACT;
            cnt_d   = first_len;
          end else begin
            state_d = ST_MISS;
            cnt_d   = CNT_W'(TIMEOUT - 1);
          end
        end
      end
      ST_ACT: begin
        if (cnt_done) begin
          if (left_q == '0) begin
            state_d = ST_IDLE;
          end else begin
            left_d = left_q - BEAT_W'(1);
            cnt_d  = next_len;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_MISS: begin
        if (cnt_done) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - CNT_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      left_q  <= left_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      width_q <= '0;
      burst_q <= 1'b0;
      dram_q  <= 1'b0;
      waits_q <= '0;
    end else if (accept) begin
      idx_q   <= idx_i;
      width_q <= width_i;
      burst_q <= burst_i;
      dram_q  <= dram_i;
      waits_q <= waits_i;
    end
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_strobe
    assign cs_o[g]  = act && !dram_q && (idx_q == PIDX_W'(g));
    assign ras_o[g] = act &&  dram_q && (idx_q == PIDX_W'(g));
  end

  assign ack_o   = act && cnt_done;
  assign err_o   = (state_q == ST_MISS) && cnt_done;
  assign busy_o  = (state_q != ST_IDLE);
  assign width_o = act ? width_q : '0;

  // R5
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_o, ras_o}));

  // R5
  ack_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> ($countones({cs_o, ras_o}) == 1));

  // R10
  err_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (({cs_o, ras_o} == '0) && !ack_o));

  // R7
  burst_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && burst_q && (left_q != '0)) |=> ack_o);

  // R8
  single_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !burst_q) |=> !ack_o);

  // R9
  width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(act)) |-> $stable(width_o));

  // R12
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(idx_q));
endmodule

// File: rtl/csdec_top.sv
module csdec_top
  import csdec_pkg::*;
#(
  parameter int NPORTS  = 4,
  parameter int BEAT_W  = 4,
  parameter int TIMEOUT = 16,
  parameter int PIDX_W  = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PIDX_W-1:0] cfg_port,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              bus_start,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BEAT_W-1:0] bus_beats,
  output logic [NPORTS-1:0] cs_o,
  output logic [NPORTS-1:0] ras_o,
  output logic              ack_o,
  output logic              err_o,
  output logic              busy_o,
  output logic [1:0]        width_o
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  port_cfg_t         cfg_arr  [NPORTS];
  logic [NPORTS-1:0] en_vec;
  logic [ADDR_W-1:0] base_arr [NPORTS];
  logic [SIZE_W-1:0] lg2_arr  [NPORTS];

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    csdec_port_regs #(.IS_BOOT(g == 0)) regs_i (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (cfg_we && (cfg_port == PIDX_W'(g))),
      .wr_sel  (cfg_sel),
      .wr_data (cfg_wdata),
      .cfg_o   (cfg_arr[g])
    );
    assign en_vec[g]   = cfg_arr[g].en;
    assign base_arr[g] = cfg_arr[g].base;
    assign lg2_arr[g]  = cfg_arr[g].lg2;
  end

  logic              hit;
  logic [PIDX_W-1:0] hit_idx;
  port_cfg_t         sel_cfg;

  csdec_window_match #(.NPORTS(NPORTS), .PIDX_W(PIDX_W)) match_i (
    .addr_i (bus_addr),
    .en_i   (en_vec),
    .base_i (base_arr),
    .lg2_i  (lg2_arr),
    .hit_o  (hit),
    .idx_o  (hit_idx)
  );

  assign sel_cfg = cfg_arr[hit_idx];

  csdec_cycle_ctrl #(
    .NPORTS(NPORTS), .BEAT_W(BEAT_W), .TIMEOUT(TIMEOUT), .PIDX_W(PIDX_W)
  ) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (bus_start),
    .beats_i (bus_beats),
    .hit_i   (hit),
    .idx_i   (hit_idx),
    .width_i (sel_cfg.width),
    .burst_i (sel_cfg.burst),
    .dram_i  (sel_cfg.dram),
    .waits_i (sel_cfg.waits),
    .cs_o    (cs_o),
    .ras_o   (ras_o),
    .ack_o   (ack_o),
    .err_o   (err_o),
    .busy_o  (busy_o),
    .width_o (width_o)
  );

  // R4
  hit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_start && !busy_o && hit) |-> en_vec[hit_idx]);
endmodule

// File: tb/csdec_top_tb_top.sv
module csdec_top_tb_top;
  localparam int NP = 4;
  localparam int TO = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_port;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        bus_start;
  logic [31:0] bus_addr;
  logic [3:0]  bus_beats;
  logic [NP-1:0] cs_o, ras_o;
  logic        ack_o, err_o, busy_o;
  logic [1:0]  width_o;

  always #5 clk = ~clk;

  csdec_top #(.NPORTS(NP), .BEAT_W(4), .TIMEOUT(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .bus_start(bus_start),
    .bus_addr(bus_addr), .bus_beats(bus_beats), .cs_o(cs_o), .ras_o(ras_o),
    .ack_o(ack_o), .err_o(err_o), .busy_o(busy_o), .width_o(width_o)
  );

  typedef struct {
    bit          is_err;
    int          cyc;
    logic [NP-1:0] cs;
    logic [NP-1:0] ras;
    logic [1:0]  width;
    string       req;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   n_run = 0, n_fail = 0, cyc = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (ack_o || err_o)) begin
      n_run++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R12 unexpected termination at cycle %0d: actual ack=%0d err=%0d expected none",
                 cyc, ack_o, err_o);
      end else begin
        e = q.pop_front();
        if (err_o !== e.is_err || ack_o !== !e.is_err || cyc != e.cyc ||
            cs_o !== e.cs || ras_o !== e.ras || (ack_o && width_o !== e.width)) begin
          n_fail++;
          $display("FAIL %s: actual err=%0d cyc=%0d cs=%b ras=%b w=%0d expected err=%0d cyc=%0d cs=%b ras=%b w=%0d",
                   e.req, err_o, cyc, cs_o, ras_o, width_o,
                   e.is_err, e.cyc, e.cs, e.ras, e.width);
        end
      end
    end
  end

  task automatic cfgw(input int port, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_port = 2'(port); cfg_sel = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] ctrl(input bit en, input int w, input bit burst,
                                       input bit dram, input int waits);
    return {20'd0, 4'(waits), 3'd0, dram, burst, 2'(w), en};
  endfunction

  task automatic access(input logic [31:0] a, input int nb, input int port,
                        input bit dram, input int w, input int waits,
                        input bit burst, input bit miss, input string req,
                        input bit poke = 1'b0);
    int s;
    exp_t x;
    @(negedge clk);
    bus_addr = a; bus_beats = 4'(nb); bus_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    s = cyc;
    bus_start = 1'b0;
    x.req = req;
    if (miss) begin
      x.is_err = 1'b1; x.cyc = s + TO - 1; x.cs = '0; x.ras = '0; x.width = '0;
      q.push_back(x);
    end else begin
      for (int k = 1; k <= nb; k++) begin
        x.is_err = 1'b0;
        x.cyc = (burst && nb > 1) ? s + waits + k : s + k * (waits + 2) - 1;
        x.cs  = dram ? '0 : NP'(1) << port;
        x.ras = dram ? NP'(1) << port : '0;
        x.width = 2'(w);
        q.push_back(x);
      end
    end
    if (poke) begin
      bus_addr = 32'h3000_0000; bus_beats = 4'd1; bus_start = 1'b1;
      @(negedge clk);
      bus_start = 1'b0;
    end
    while (busy_o) @(negedge clk);
    chk((cs_o | ras_o) == '0, "R5", "strobes idle after access", longint'({cs_o, ras_o}), 0);
    chk(q.size() == 0, req, "all expected terminations seen", q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_port = '0; cfg_sel = '0; cfg_wdata = '0;
    bus_start = 1'b0; bus_addr = '0; bus_beats = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({cs_o, ras_o, ack_o, err_o, busy_o} == '0, "R1", "outputs idle after reset",
        longint'({cs_o, ras_o, ack_o, err_o, busy_o}), 0);

    // R1: boot window covers everything, 8-bit, 15 waits
    access(32'hDEAD_BEEF, 1, 0, 0, 0, 15, 0, 0, "R1");
    access(32'h0000_0004, 1, 0, 0, 0, 15, 0, 0, "R1");

    cfgw(0, 1, 28);
    cfgw(0, 2, ctrl(1, 0, 0, 0, 1));
    cfgw(1, 0, 32'h1000_0ABC);
    cfgw(1, 1, 20);
    cfgw(1, 2, ctrl(1, 2, 1, 0, 2));

    // R2 R7 R9: burst of 4, 32-bit, base low bits ignored
    access(32'h1004_0000, 4, 1, 0, 2, 2, 1, 0, "R7");
    // R6: single beat on burst port
    access(32'h100F_FFFF, 1, 1, 0, 2, 2, 1, 0, "R6");
    // R8: single mode two beats
    access(32'h0000_0010, 2, 0, 0, 0, 1, 0, 0, "R8");
    // R2: just past port1 window -> miss; R10
    access(32'h1010_0000, 1, 0, 0, 0, 0, 0, 1, "R2");
    access(32'h2000_0000, 1, 0, 0, 0, 0, 0, 1, "R10");

    // R3: size clamps, R5 DRAM row strobe
    cfgw(2, 0, 32'h3000_0000);
    cfgw(2, 1, 4);
    cfgw(2, 2, ctrl(1, 1, 0, 1, 0));
    access(32'h3000_0FFF, 1, 2, 1, 1, 0, 0, 0, "R5");
    access(32'h3000_1000, 1, 0, 0, 0, 0, 0, 1, "R3");
    cfgw(3, 0, 32'h4000_0000);
    cfgw(3, 1, 40);
    cfgw(3, 2, ctrl(1, 3, 0, 0, 3));
    access(32'h4FFF_FFFC, 1, 3, 0, 2, 3, 0, 0, "R3");
    access(32'h5000_0000, 1, 0, 0, 0, 0, 0, 1, "R3");

    // R4: overlap, lower port wins
    cfgw(3, 0, 32'h1000_0000);
    access(32'h1004_0000, 1, 1, 0, 2, 2, 1, 0, "R4");
    access(32'h1100_0000, 1, 3, 0, 2, 3, 0, 0, "R4");

    // R11: disabled port never matches
    cfgw(1, 2, ctrl(0, 2, 1, 0, 2));
    access(32'h1004_0000, 1, 3, 0, 2, 3, 0, 0, "R11");

    // R12: start while busy is ignored
    access(32'h1100_0000, 1, 3, 0, 2, 3, 0, 0, "R12", 1'b1);
    repeat (4) @(negedge clk);
    chk(q.size() == 0 && !busy_o, "R12", "no second access started",
        longint'(busy_o), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule